// File: doc/BRIEF.md
# Energy-to-Pulse Frequency Generator

This block turns signed power measurements into trains of fixed-width pulses. The pulse rate follows the magnitude of the chosen power. It is the usual test output of an energy meter, and it lets a host count energy by counting pulses.

Several generator lanes run side by side. There are three by default, so active, reactive and apparent energy can be output at the same time. Each lane has its own controls:

- a source selector that picks one of nine power values,
- an enable,
- a pulse-width field,
- a frequency-range field.

On every sample strobe, a lane adds the absolute value of its chosen power to an accumulator. Each time the accumulator reaches the lane's threshold, the lane takes the threshold off the accumulator and asks for one pulse. Requests that arrive while a pulse is running are queued and issued one after another.

The nine power values arrive on one flat bus together with a single-cycle `sample_valid_i` strobe. The strobe is always accepted in the cycle it is high. There is no ready signal and no back-pressure: the producer never waits, and a sample is never dropped. The configuration pins are plain levels.

Top module: `energy_pulse_gen`

## Requirements
- R1: While reset is asserted and in the first cycle after it, every `pulse_o` bit is 0.
- R2: Selector code k in 0..8 picks power slot k, which sits at bits `[k*PWR_W +: PWR_W]` of `pwr_i`. The slot order is: total active, total reactive, total apparent, channel-1 active, channel-2 active, channel-1 reactive, channel-2 reactive, channel-1 apparent, channel-2 apparent. Codes 9..15 count as zero power and give no pulses.
- R3: Only the magnitude of the chosen power is accumulated. A negative sample gives the same pulse count as its positive counterpart.
- R4: The threshold is 2^(THR_LOG2 + range), which is 256 times 2^range at the default THR_LOG2 = 8. One pulse is issued for each threshold of accumulated magnitude. Any remainder is carried over to later samples.
- R5: Each pulse stays high for exactly (pw+1)*PRESCALE clock cycles. The pulse-width value is captured when the pulse starts.
- R6: A threshold crossing that happens while a pulse is high is queued. It starts a new pulse after the current one ends. There is exactly one low cycle between back-to-back pulses, and the queue saturates at 2^PEND_W-1 entries.
- R7: While a lane's enable is 0, its pulse output is 0 and strobes are ignored. Dropping the enable also cuts a running pulse, empties the accumulator and empties the queue.
- R8: The lanes are independent: each lane follows only its own selector, enable, width and range.
- R9: A crossing caused by a strobe taken at clock edge N makes the pulse go high right after edge N+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock |
| rst_i | input | 1 | Synchronous active-high reset |
| pwr_i | input | NUM_SRC*PWR_W | Nine signed power values; slot k at bits [k*PWR_W +: PWR_W] |
| sample_valid_i | input | 1 | Sample strobe; the powers are taken in cycles where it is high |
| sel_i | input | NUM_GEN*4 | Source selector, 4 bits per lane |
| en_i | input | NUM_GEN | Lane enable |
| pw_i | input | NUM_GEN*8 | Pulse-width setting, 8 bits per lane |
| rng_i | input | NUM_GEN*4 | Frequency range, 4 bits per lane |
| pulse_o | output | NUM_GEN | Energy pulse, one bit per lane |

## Verification
The main function is exercised with four kinds of input, each of which separates a different fault:

- **Equal strobes, range 0 then range 2.** Steady trains of equal samples show that the threshold follows the range field. Stopping the totals just below and just above a multiple of the threshold shows whether the remainder is carried over or thrown away.
- **Mirrored signed samples.** Negative samples that mirror the positive ones separate magnitude accumulation from signed accumulation.
- **One large sample.** A single sample worth several thresholds, with a long pulse width, forces crossings to happen while a pulse is high. The resulting pulse count and widths show whether the queue works.
- **One lit slot, all selector codes.** Walking the selector over every code while only one slot is non-zero catches a wrong slot mapping. It also catches any leak through the unused codes.

// File: rtl/epg_pkg.sv
package epg_pkg;
  localparam int SEL_W   = 4;
  localparam int PW_W    = 8;
  localparam int RNG_W   = 4;
  localparam int NUM_SRC = 9;

  // Power slot order on the input bus; matches the selector codes.
  typedef enum logic [SEL_W-1:0] {
    SRC_P_TOTAL = 4'd0,
    SRC_Q_TOTAL = 4'd1,
    SRC_S_TOTAL = 4'd2,
    SRC_P_CH1   = 4'd3,
    SRC_P_CH2   = 4'd4,
    SRC_Q_CH1   = 4'd5,
    SRC_Q_CH2   = 4'd6,
    SRC_S_CH1   = 4'd7,
    SRC_S_CH2   = 4'd8
  } src_e;

  function automatic logic sel_in_range(input logic [SEL_W-1:0] s);
    return s < SEL_W'(NUM_SRC);
  endfunction
endpackage

// File: rtl/epg_src_mag.sv
module epg_src_mag
  import epg_pkg::*;
#(
  parameter int PWR_W = 16
) (
  input  logic [NUM_SRC*PWR_W-1:0] pwr_i,
  input  logic [SEL_W-1:0]         sel_i,
  output logic [PWR_W-1:0]         mag_o
);
  logic [PWR_W-1:0] picked;

  always_comb begin
    picked = '0;
    for (int k = 0; k < NUM_SRC; k++) begin
      if (sel_i == SEL_W'(k)) picked = pwr_i[k*PWR_W +: PWR_W];
    end
    if (!sel_in_range(sel_i)) picked = '0;
  end

  // Two's-complement magnitude; the most negative value maps to 2^(PWR_W-1).
  assign mag_o = picked[PWR_W-1] ? (~picked + 1'b1) : picked;
endmodule

// File: rtl/epg_accum.sv
module epg_accum
  import epg_pkg::*;
#(
  parameter int PWR_W    = 16,
  parameter int THR_LOG2 = 8,
  parameter int ACC_W    = 25
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             en_i,
  input  logic             valid_i,
  input  logic [PWR_W-1:0] mag_i,
  input  logic [RNG_W-1:0] rng_i,
  output logic             cross_o
);
  logic [ACC_W-1:0] acc_q, thr, base, addend, acc_d;
  logic [ACC_W:0]   sum;

  always_comb begin
    thr     = {{(ACC_W-1){1'b0}}, 1'b1} << (THR_LOG2 + int'(rng_i));
    cross_o = en_i && (acc_q >= thr);
    base    = cross_o ? (acc_q - thr) : acc_q;
    addend  = valid_i ? ACC_W'(mag_i) : '0;
    sum     = {1'b0, base} + {1'b0, addend};
    acc_d   = sum[ACC_W] ? '1 : sum[ACC_W-1:0];
  end

  always_ff @(posedge clk_i) begin
    if (rst_i || !en_i) acc_q <= '0;
    else                acc_q <= acc_d;
  end
endmodule

// File: rtl/epg_pulse_timer.sv
module epg_pulse_timer
  import epg_pkg::*;
#(
  parameter int PRESCALE = 4,
  parameter int PEND_W   = 4
) (
  input  logic            clk_i,
  input  logic            rst_i,
  input  logic            en_i,
  input  logic            cross_i,
  input  logic [PW_W-1:0] pw_i,
  output logic            pulse_o
);
  localparam int SUB_W = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
  localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(PRESCALE - 1);

  logic              pulse_q;
  logic [SUB_W-1:0]  sub_q;
  logic [PW_W-1:0]   wcnt_q;
  logic [PEND_W-1:0] pend_q, pend_d;
  logic [PEND_W:0]   pend_sum;
  logic              start;

  always_comb begin
    start    = en_i && !pulse_q && ((pend_q != '0) || cross_i);
    pend_sum = {1'b0, pend_q} + (PEND_W+1)'(cross_i) - (PEND_W+1)'(start);
    pend_d   = pend_sum[PEND_W] ? '1 : pend_sum[PEND_W-1:0];
  end

  always_ff @(posedge clk_i) begin
    if (rst_i || !en_i) begin
      pulse_q <= 1'b0;
      sub_q   <= '0;
      wcnt_q  <= '0;
      pend_q  <= '0;
    end else begin
      pend_q <= pend_d;
      if (start) begin
        pulse_q <= 1'b1;
        sub_q   <= '0;
        wcnt_q  <= pw_i;
      end else if (pulse_q) begin
        if (sub_q == SUB_LAST) begin
          sub_q <= '0;
          if (wcnt_q == '0) pulse_q <= 1'b0;
          else              wcnt_q  <= wcnt_q - 1'b1;
        end else begin
          sub_q <= sub_q + 1'b1;
        end
      end
    end
  end

  assign pulse_o = pulse_q;
endmodule

// File: rtl/energy_pulse_gen.sv
module energy_pulse_gen
  import epg_pkg::*;
#(
  parameter int NUM_GEN  = 3,
  parameter int PWR_W    = 16,
  parameter int THR_LOG2 = 8,
  parameter int PRESCALE = 4,
  parameter int PEND_W   = 4
) (
  input  logic                     clk_i,
  input  logic                     rst_i,
  input  logic [NUM_SRC*PWR_W-1:0] pwr_i,
  input  logic                     sample_valid_i,
  input  logic [NUM_GEN*SEL_W-1:0] sel_i,
  input  logic [NUM_GEN-1:0]       en_i,
  input  logic [NUM_GEN*PW_W-1:0]  pw_i,
  input  logic [NUM_GEN*RNG_W-1:0] rng_i,
  output logic [NUM_GEN-1:0]       pulse_o
);
  // Room for the largest threshold plus one more sample.
  localparam int ACC_W = THR_LOG2 + (1 << RNG_W) + 1;

  logic [PWR_W-1:0]   mag_w [NUM_GEN];
  logic [NUM_GEN-1:0] cross_w;

  for (genvar g = 0; g < NUM_GEN; g++) begin : g_lane
    epg_src_mag #(.PWR_W(PWR_W)) u_mux (
      .pwr_i (pwr_i),
      .sel_i (sel_i[g*SEL_W +: SEL_W]),
      .mag_o (mag_w[g])
    );

    epg_accum #(.PWR_W(PWR_W), .THR_LOG2(THR_LOG2), .ACC_W(ACC_W)) u_acc (
      .clk_i   (clk_i),
      .rst_i   (rst_i),
      .en_i    (en_i[g]),
      .valid_i (sample_valid_i),
      .mag_i   (mag_w[g]),
      .rng_i   (rng_i[g*RNG_W +: RNG_W]),
      .cross_o (cross_w[g])
    );

    epg_pulse_timer #(.PRESCALE(PRESCALE), .PEND_W(PEND_W)) u_tmr (
      .clk_i   (clk_i),
      .rst_i   (rst_i),
      .en_i    (en_i[g]),
      .cross_i (cross_w[g]),
      .pw_i    (pw_i[g*PW_W +: PW_W]),
      .pulse_o (pulse_o[g])
    );
  end
endmodule

// File: rtl/epg_checker.sv
module epg_checker
  import epg_pkg::*;
#(
  parameter int NUM_GEN  = 3,
  parameter int PRESCALE = 4
) (
  input logic                    clk_i,
  input logic                    rst_i,
  input logic [NUM_GEN-1:0]      en_i,
  input logic [NUM_GEN*PW_W-1:0] pw_i,
  input logic [NUM_GEN-1:0]      pulse_o,
  input logic [NUM_GEN-1:0]      cross_i
);
  localparam int HC_W = PW_W + $clog2(PRESCALE + 1) + 2;

  for (genvar g = 0; g < NUM_GEN; g++) begin : g_chk
    logic [HC_W-1:0] hcnt;
    logic [PW_W-1:0] pw_q;

    always_ff @(posedge clk_i) begin
      if (rst_i) begin
        hcnt <= '0;
        pw_q <= '0;
      end else begin
        hcnt <= pulse_o[g] ? hcnt + 1'b1 : '0;
        if (!pulse_o[g]) pw_q <= pw_i[g*PW_W +: PW_W];
      end
    end

    // R7: a disabled lane is silent in the next cycle
    a_r7_disabled_quiet: assert property (@(posedge clk_i) disable iff (rst_i)
      !en_i[g] |=> !pulse_o[g]);

    // R5: a pulse that ends normally lasted (pw+1)*PRESCALE cycles
    a_r5_width: assert property (@(posedge clk_i) disable iff (rst_i)
      ($fell(pulse_o[g]) && $past(en_i[g])) |->
        (hcnt == HC_W'((int'(pw_q) + 1) * PRESCALE)));

    // R9: a crossing seen while idle starts a pulse at the next edge
    a_r9_cross_starts: assert property (@(posedge clk_i) disable iff (rst_i)
      (en_i[g] && cross_i[g] && !pulse_o[g]) |=> pulse_o[g]);

    // R8: a lane only rises when it was enabled
    a_r8_rise_needs_enable: assert property (@(posedge clk_i) disable iff (rst_i)
      $rose(pulse_o[g]) |-> $past(en_i[g]));
  end
endmodule

bind energy_pulse_gen epg_checker #(.NUM_GEN(NUM_GEN), .PRESCALE(PRESCALE)) u_chk (
  .clk_i   (clk_i),
  .rst_i   (rst_i),
  .en_i    (en_i),
  .pw_i    (pw_i),
  .pulse_o (pulse_o),
  .cross_i (cross_w)
);

// File: tb/energy_pulse_gen_test.sv
module energy_pulse_gen_test;
  localparam int CLK_PERIOD = 10;
  localparam int NG = 3;
  localparam int PW = 16;
  localparam int NS = 9;
  localparam int PS = 4;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic [NS*PW-1:0] pwr = '0;
  logic           valid = 1'b0;
  logic [NG*4-1:0] sel = '0;
  logic [NG-1:0]   en = '0;
  logic [NG*8-1:0] pw = '0;
  logic [NG*4-1:0] rng = '0;
  logic [NG-1:0]   pulse;

  int errors = 0;
  int checks = 0;
  int rises [NG];
  int hlen  [NG];
  int lastw [NG];
  logic prev [NG];
  logic wchk = 1'b1;
  logic done = 1'b0;

  energy_pulse_gen uut (
    .clk_i(clk), .rst_i(rst), .pwr_i(pwr), .sample_valid_i(valid),
    .sel_i(sel), .en_i(en), .pw_i(pw), .rng_i(rng), .pulse_o(pulse)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Pulse monitor, sampled away from the active edge
  initial for (int g = 0; g < NG; g++) begin rises[g] = 0; hlen[g] = 0; lastw[g] = 0; prev[g] = 1'b0; end
  always @(negedge clk) begin
    for (int g = 0; g < NG; g++) begin
      if (pulse[g] && !prev[g]) rises[g]++;
      if (pulse[g]) hlen[g]++;
      else if (prev[g]) begin
        lastw[g] = hlen[g];
        if (wchk && !rst) check("R5 width", hlen[g], (int'(pw[g*8 +: 8]) + 1) * PS);
        hlen[g] = 0;
      end
      prev[g] = pulse[g];
    end
  end

  task automatic clr_counts();
    @(posedge clk);
    for (int g = 0; g < NG; g++) rises[g] = 0;
  endtask

  task automatic set_slot(input int k, input logic [PW-1:0] v);
    pwr[k*PW +: PW] = v;
  endtask

  task automatic cfg(input int g, input logic [3:0] s, input logic [7:0] w,
                     input logic [3:0] r, input logic e);
    sel[g*4 +: 4] = s;
    pw[g*8 +: 8]  = w;
    rng[g*4 +: 4] = r;
    en[g]         = e;
  endtask

  task automatic strobe();
    @(negedge clk) valid = 1'b1;
    @(negedge clk) valid = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clear_all();
    @(negedge clk);
    en = '0; pwr = '0; valid = 1'b0;
    idle(2);
    clr_counts();
    @(negedge clk);
  endtask

  task automatic t_reset();
    idle(1);
    check("R1 pulse during reset", int'(pulse), 0);
    @(negedge clk) rst = 1'b0;
    idle(1);
    check("R1 pulse after reset", int'(pulse), 0);
  endtask

  task automatic t_latency_width();
    clear_all();
    set_slot(0, 16'd300);
    cfg(0, 4'd0, 8'd2, 4'd0, 1'b1);
    strobe();
    check("R9 low after strobe edge", int'(pulse[0]), 0);
    @(negedge clk);
    check("R9 high one edge later", int'(pulse[0]), 1);
    idle(30);
    check("R9 one pulse", rises[0], 1);
    check("R5 last width", lastw[0], 12);
  endtask

  task automatic t_rate();
    clear_all();
    set_slot(0, 16'd100);
    cfg(0, 4'd0, 8'd0, 4'd0, 1'b1);
    for (int i = 0; i < 10; i++) begin strobe(); idle(6); end
    idle(20);
    check("R4 range0 1000/256", rises[0], 3);
    clear_all();
    set_slot(0, 16'd100);
    cfg(0, 4'd0, 8'd0, 4'd2, 1'b1);
    for (int i = 0; i < 41; i++) strobe();
    idle(20);
    check("R4 range2 4100/1024", rises[0], 4);
    for (int i = 0; i < 10; i++) strobe();
    idle(20);
    check("R4 remainder below threshold", rises[0], 4);
    strobe();
    idle(20);
    check("R4 remainder carried", rises[0], 5);
  endtask

  task automatic t_sign();
    clear_all();
    set_slot(0, 16'hFF9C);
    cfg(0, 4'd0, 8'd0, 4'd0, 1'b1);
    for (int i = 0; i < 10; i++) begin strobe(); idle(6); end
    idle(20);
    check("R3 negative magnitude", rises[0], 3);
  endtask

  task automatic t_select();
    for (int k = 0; k < NS; k++) begin
      clear_all();
      set_slot(k, 16'd300);
      cfg(0, 4'(k), 8'd0, 4'd0, 1'b1);
      strobe();
      idle(20);
      check($sformatf("R2 code %0d picks slot %0d", k, k), rises[0], 1);
    end
    clear_all();
    set_slot(5, 16'd300);
    cfg(0, 4'd3, 8'd0, 4'd0, 1'b1);
    for (int i = 0; i < 3; i++) strobe();
    idle(20);
    check("R2 other slot ignored", rises[0], 0);
    clear_all();
    for (int k = 0; k < NS; k++) set_slot(k, 16'h7FFF);
    for (int c = 9; c < 16; c++) begin
      cfg(0, 4'(c), 8'd0, 4'd0, 1'b1);
      for (int i = 0; i < 3; i++) strobe();
    end
    idle(20);
    check("R2 codes 9..15 zero power", rises[0], 0);
  endtask

  task automatic t_queue();
    clear_all();
    set_slot(0, 16'd1000);
    cfg(0, 4'd0, 8'd9, 4'd0, 1'b1);
    strobe();
    idle(200);
    check("R6 queued crossings", rises[0], 3);
    check("R6 queued width", lastw[0], 40);
  endtask

  task automatic t_enable();
    clear_all();
    set_slot(0, 16'd30000);
    cfg(0, 4'd0, 8'd0, 4'd0, 1'b0);
    for (int i = 0; i < 4; i++) strobe();
    idle(10);
    check("R7 disabled silent", rises[0], 0);
    en[0] = 1'b1;
    idle(20);
    check("R7 no stored energy", rises[0], 0);
    clear_all();
    set_slot(0, 16'd200);
    cfg(0, 4'd0, 8'd0, 4'd0, 1'b1);
    strobe();
    en[0] = 1'b0; idle(1); en[0] = 1'b1;
    set_slot(0, 16'd100);
    strobe();
    idle(20);
    check("R7 accumulator cleared", rises[0], 0);
    clear_all();
    wchk = 1'b0;
    set_slot(0, 16'd1000);
    cfg(0, 4'd0, 8'd9, 4'd0, 1'b1);
    strobe();
    idle(10);
    en[0] = 1'b0; idle(1);
    check("R7 pulse cut", int'(pulse[0]), 0);
    en[0] = 1'b1;
    set_slot(0, 16'd100);
    strobe();
    idle(200);
    check("R7 queue cleared", rises[0], 1);
    wchk = 1'b1;
  endtask

  task automatic t_parallel();
    clear_all();
    set_slot(0, 16'd100);
    set_slot(1, 16'hFED4);
    set_slot(2, 16'd5000);
    cfg(0, 4'd0, 8'd0, 4'd0, 1'b1);
    cfg(1, 4'd1, 8'd0, 4'd0, 1'b1);
    cfg(2, 4'd2, 8'd0, 4'd0, 1'b0);
    for (int i = 0; i < 10; i++) begin strobe(); idle(8); end
    idle(200);
    check("R8 lane0 count", rises[0], 3);
    check("R8 lane1 count", rises[1], 11);
    check("R8 lane2 disabled", rises[2], 0);
  endtask

  initial begin
    t_reset();
    t_latency_width();
    t_rate();
    t_sign();
    t_select();
    t_queue();
    t_enable();
    t_parallel();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog (all requirements): actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule